// File: doc/BRIEF.md
# Write-Once Watchdog Timer With Service Sequence

This block is a memory-mapped system watchdog. Software programs it once after power-on reset through a control word. That single write sets the timeout count, the freeze permission, the enable, the choice between a reset request and an interrupt on expiry, and the clock prescale. The control word then locks. A disabled watchdog cannot be switched on later, and an enabled one cannot be switched off. Reading the control word back returns only what took effect, so a refused enable can be seen.

Once enabled, a 17-bit counter counts down from the timeout value. The count is visible in a read-only count register. Software keeps the system alive by writing two key values to the service register, one after the other in a fixed order. When the counter runs out, the block either pulses a reset request or raises a level interrupt, and then restarts from the timeout value. A sticky status bit records that a watchdog reset request was issued.

Top module: `lockwd_top`

Registers are addressed by the word index on `addr_i`:

| Index | Register | Access |
|-------|----------|--------|
| 0 | control | read/write once |
| 1 | count | read-only |
| 2 | service | write |
| 3 | status | read, write 1 to clear |

A write happens in any cycle where `req_i` and `we_i` are both high. Read data is combinational on `addr_i`.

## Requirements
- R1: After rst_ni is released, the control, count and status registers read 0, and irq_o and rst_req_o are low.
- R2: The first write to the control register (index 0) stores the following fields, and any later write is ignored:
  - bits 31:16: timeout count
  - bit 3: freeze permission
  - bit 2: enable
  - bit 1: select (1 = reset, 0 = interrupt)
  - bit 0: prescale

  A read of index 0 returns the stored fields in those positions, with all other bits 0.
- R3: The counter reloads with the timeout count, and the prescaler clears, only when a service-register (index 2) write with low half 0x556C is followed by the next service-register write with low half 0xAA39. A 0xAA39 write without the preceding key does nothing. Any other value cancels a half-finished sequence.
- R4: When enabled without prescale, the counter decrements once per clock. It reads in bits 16:0 of index 1. A decrement from 1 is an expiry, which reloads the timeout count. A timeout count of 0 loads as 0x10000.
- R5: With the prescale bit set, the counter decrements once every 2^16 clocks. The parameter SHORT_PRESC selects 2^11 instead. The first decrement comes 2^16 clocks after the enabling write.
- R6: The counter holds while freeze_i is high and the freeze permission bit is set. With the permission bit clear, freeze_i has no effect.
- R7: With select 0, an expiry raises irq_o. irq_o stays high through further expiries until a successful service sequence clears it.
- R8: With select 1, an expiry gives a one-cycle pulse on rst_req_o and sets bit 0 of the status register (index 3). Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R9: If the first control write leaves enable at 0, the counter stays at 0 and neither irq_o nor rst_req_o is ever asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| freeze_i | input | 1 | Debug freeze request |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Expiry interrupt level |
| rst_req_o | output | 1 | Expiry reset request pulse |

## Verification
The assertions assume that rst_ni is the only source of reset, so the lock and the sticky bit are cleared by nothing else. They also assume that every write is a single-cycle strobe with stable data.

The bench keeps to these limits. It returns to power-on reset before each scenario, because the control word can be written only once. It issues every access as a one-cycle write set up at the falling edge. Expiry windows are kept short, except in the one prescale scenario, so that the counts expected at each falling edge can be derived directly from the timeout value.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int TC_W   = 16;
  localparam int CNT_W  = TC_W + 1;
  localparam int FLG_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_SVC  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam logic [TC_W-1:0] KEY_ARM  = 16'h556C;
  localparam logic [TC_W-1:0] KEY_FIRE = 16'hAA39;

  // flag positions inside the low nibble of the control word
  localparam int B_PRE  = 0;
  localparam int B_RSEL = 1;
  localparam int B_EN   = 2;
  localparam int B_FRZ  = 3;

  typedef struct packed {
    logic [TC_W-1:0] tc;
    logic            frz;
    logic            en;
    logic            rsel;
    logic            pre;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] reload_f(logic [TC_W-1:0] tc);
    if (tc == '0) reload_f = {1'b1, {TC_W{1'b0}}};
    else          reload_f = {1'b0, tc};
  endfunction
endpackage

// File: rtl/lockwd_ctrl.sv
module lockwd_ctrl
  import lockwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [TC_W-1:0]   tc_i,
  input  logic [FLG_W-1:0]  flg_i,
  output ctrl_t             ctrl_o,
  output logic              locked_o,
  output logic              load_o,
  output logic [TC_W-1:0]   load_tc_o
);
  ctrl_t ctrl_q;
  logic  locked_q;
  logic  first_wr;

  assign first_wr = wr_i & ~locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else if (first_wr) begin
      ctrl_q.tc   <= tc_i;
      ctrl_q.frz  <= flg_i[B_FRZ];
      ctrl_q.en   <= flg_i[B_EN];
      ctrl_q.rsel <= flg_i[B_RSEL];
      ctrl_q.pre  <= flg_i[B_PRE];
      locked_q    <= 1'b1;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign locked_o  = locked_q;
  assign load_o    = first_wr & flg_i[B_EN];
  assign load_tc_o = tc_i;
endmodule

// File: rtl/lockwd_svc.sv
module lockwd_svc
  import lockwd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [TC_W-1:0] key_i,
  output logic            svc_o,
  output logic            armed_o
);
  logic armed_q;

  // any service write other than the arming key drops the armed state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= (key_i == KEY_ARM);
  end

  assign svc_o   = wr_i & armed_q & (key_i == KEY_FIRE);
  assign armed_o = armed_q;
endmodule

// File: rtl/lockwd_core.sv
module lockwd_core
  import lockwd_pkg::*;
#(
  parameter int PRESC_LOG2 = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             load_i,
  input  logic [TC_W-1:0]  load_tc_i,
  input  logic             svc_i,
  input  logic             freeze_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, rreq_q;
  logic             active, tick, restart, expire;

  assign active  = ctrl_i.en & ~(freeze_i & ctrl_i.frz);
  assign restart = svc_i & ctrl_i.en;

  generate
    if (PRESC_LOG2 > 0) begin : g_presc
      logic [PRESC_LOG2-1:0] presc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   presc_q <= '0;
        else if (load_i || restart)    presc_q <= '0;
        else if (active && ctrl_i.pre) presc_q <= presc_q + 1'b1;
      end
      assign tick = active & (~ctrl_i.pre | (&presc_q));
    end else begin : g_nopresc
      assign tick = active;
    end
  endgenerate

  assign expire = tick & ~restart & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= reload_f(load_tc_i);
    else if (restart || expire)  cnt_q <= reload_f(ctrl_i.tc);
    else if (tick)               cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      rreq_q <= expire & ctrl_i.rsel;
      if (restart)                      irq_q <= 1'b0;
      else if (expire && !ctrl_i.rsel)  irq_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expire_o  = expire;
  assign irq_o     = irq_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
  import lockwd_pkg::*;
#(
  parameter bit SHORT_PRESC = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int PRESC_LOG2 = SHORT_PRESC ? 11 : 16;

  logic             wr, wr_ctrl, wr_svc, wr_stat;
  ctrl_t            ctrl;
  logic             locked, load, svc, armed, expire, sticky_q;
  logic [TC_W-1:0]  load_tc;
  logic [CNT_W-1:0] cnt;

  assign wr      = req_i & we_i;
  assign wr_ctrl = wr & (addr_i == A_CTRL);
  assign wr_svc  = wr & (addr_i == A_SVC);
  assign wr_stat = wr & (addr_i == A_STAT);

  lockwd_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .tc_i      (wdata_i[DATA_W-1 -: TC_W]),
    .flg_i     (wdata_i[FLG_W-1:0]),
    .ctrl_o    (ctrl),
    .locked_o  (locked),
    .load_o    (load),
    .load_tc_o (load_tc)
  );

  lockwd_svc u_svc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_svc),
    .key_i   (wdata_i[TC_W-1:0]),
    .svc_o   (svc),
    .armed_o (armed)
  );

  lockwd_core #(.PRESC_LOG2(PRESC_LOG2)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .load_i    (load),
    .load_tc_i (load_tc),
    .svc_i     (svc),
    .freeze_i  (freeze_i),
    .cnt_o     (cnt),
    .expire_o  (expire),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sticky_q <= 1'b0;
    else if (expire && ctrl.rsel)     sticky_q <= 1'b1;
    else if (wr_stat && wdata_i[0])   sticky_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = {ctrl.tc, {(DATA_W-TC_W-FLG_W){1'b0}},
                         ctrl.frz, ctrl.en, ctrl.rsel, ctrl.pre};
      A_CNT:  rdata_o = {{(DATA_W-CNT_W){1'b0}}, cnt};
      A_SVC:  rdata_o = {{(DATA_W-1){1'b0}}, armed};
      A_STAT: rdata_o = {{(DATA_W-1){1'b0}}, sticky_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lockwd_chk.sv
module lockwd_chk
  import lockwd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             freeze_i,
  input logic             locked,
  input ctrl_t            ctrl,
  input logic             svc,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             sticky
);
  a_r2_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(ctrl));

  a_r3_svc_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc && ctrl.en) |=> (cnt == reload_f($past(ctrl.tc))));

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.en |-> (cnt != '0));

  a_r6_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && ctrl.frz && freeze_i && !svc) |=> $stable(cnt));

  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !svc) |=> irq_o);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  a_r8_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> sticky);

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |-> (!irq_o && !rst_req_o));
endmodule

bind lockwd_top lockwd_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .freeze_i  (freeze_i),
  .locked    (locked),
  .ctrl      (ctrl),
  .svc       (svc),
  .cnt       (cnt),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .sticky    (sticky_q)
);

// File: tb/lockwd_top_tb_top.sv
`timescale 1ns/1ps
module lockwd_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        freeze_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  lockwd_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .freeze_i(freeze_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  localparam logic [1:0] I_CTRL = 2'd0, I_CNT = 2'd1, I_SVC = 2'd2, I_STAT = 2'd3;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge and return at one
  task automatic do_reset();
    rst_ni = 1'b0; freeze_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic chk_reg(string req, logic [1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk_reg("R1 ctrl", I_CTRL, 32'h0);
    chk_reg("R1 count", I_CNT, 32'h0);
    chk_reg("R1 status", I_STAT, 32'h0);
    check("R1 outputs", {30'd0, irq_o, rst_req_o}, 32'h0);
  endtask

  task automatic t_write_once();
    do_reset();
    wr(I_CTRL, 32'h0064_0004);
    chk_reg("R2 first write", I_CTRL, 32'h0064_0004);
    wr(I_CTRL, 32'hFFFF_000B);
    chk_reg("R2 second write ignored", I_CTRL, 32'h0064_0004);
    chk_reg("R2 count kept", I_CNT, 32'd99);
  endtask

  task automatic t_refused();
    do_reset();
    wr(I_CTRL, 32'h0005_0000);
    wr(I_CTRL, 32'h0005_0004);
    chk_reg("R9 enable refused", I_CTRL, 32'h0005_0000);
    repeat (10) @(negedge clk_i);
    chk_reg("R9 count idle", I_CNT, 32'h0);
    check("R9 outputs quiet", {30'd0, irq_o, rst_req_o}, 32'h0);
  endtask

  task automatic t_count();
    do_reset();
    freeze_i = 1'b1;   // permission bit clear: no effect
    wr(I_CTRL, 32'h0005_0004);
    chk_reg("R4 loaded", I_CNT, 32'd5);
    @(negedge clk_i);
    chk_reg("R6 freeze ignored", I_CNT, 32'd4);
    repeat (3) @(negedge clk_i);
    chk_reg("R4 at one", I_CNT, 32'd1);
    check("R7 no irq yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk_i);
    chk_reg("R4 reload on expiry", I_CNT, 32'd5);
    check("R7 irq on expiry", {31'd0, irq_o}, 32'd1);
    check("R7 no reset pulse", {31'd0, rst_req_o}, 32'd0);
    repeat (5) @(negedge clk_i);
    check("R7 irq held", {31'd0, irq_o}, 32'd1);
    freeze_i = 1'b0;
  endtask

  task automatic t_zero();
    do_reset();
    wr(I_CTRL, 32'h0000_0004);
    chk_reg("R4 zero means 65536", I_CNT, 32'h0001_0000);
    @(negedge clk_i);
    chk_reg("R4 zero decrement", I_CNT, 32'h0000_FFFF);
  endtask

  task automatic t_keys();
    do_reset();
    wr(I_CTRL, 32'h000A_0004);
    wr(I_SVC, 32'h0000_AA39);
    chk_reg("R3 lone second key", I_CNT, 32'd9);
    wr(I_SVC, 32'h0000_556C);
    wr(I_SVC, 32'h0000_1234);
    wr(I_SVC, 32'h0000_AA39);
    chk_reg("R3 broken sequence", I_CNT, 32'd6);
    wr(I_SVC, 32'h0000_556C);
    wr(I_SVC, 32'h0000_AA39);
    chk_reg("R3 good sequence", I_CNT, 32'd10);
    repeat (10) @(negedge clk_i);
    check("R7 irq after expiry", {31'd0, irq_o}, 32'd1);
    wr(I_SVC, 32'h0000_556C);
    check("R7 irq stays armed", {31'd0, irq_o}, 32'd1);
    wr(I_SVC, 32'h0000_AA39);
    check("R7 irq cleared by service", {31'd0, irq_o}, 32'd0);
    chk_reg("R3 reload after irq", I_CNT, 32'd10);
  endtask

  task automatic t_freeze();
    do_reset();
    wr(I_CTRL, 32'h000A_000C);
    freeze_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk_reg("R6 frozen", I_CNT, 32'd10);
    freeze_i = 1'b0;
    @(negedge clk_i);
    chk_reg("R6 resumed", I_CNT, 32'd9);
  endtask

  task automatic t_reset_mode();
    do_reset();
    wr(I_CTRL, 32'h0014_0006);
    repeat (19) @(negedge clk_i);
    chk_reg("R8 count at one", I_CNT, 32'd1);
    check("R8 no pulse yet", {31'd0, rst_req_o}, 32'd0);
    @(negedge clk_i);
    check("R8 pulse", {31'd0, rst_req_o}, 32'd1);
    check("R8 no irq", {31'd0, irq_o}, 32'd0);
    chk_reg("R8 sticky set", I_STAT, 32'd1);
    @(negedge clk_i);
    check("R8 pulse ends", {31'd0, rst_req_o}, 32'd0);
    wr(I_STAT, 32'h0);
    chk_reg("R8 write 0 keeps", I_STAT, 32'd1);
    wr(I_STAT, 32'h1);
    chk_reg("R8 write 1 clears", I_STAT, 32'd0);
  endtask

  task automatic t_presc();
    do_reset();
    wr(I_CTRL, 32'h0002_0005);
    repeat (65535) @(negedge clk_i);
    chk_reg("R5 before prescale tick", I_CNT, 32'd2);
    @(negedge clk_i);
    chk_reg("R5 prescale tick", I_CNT, 32'd1);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_write_once();
    t_refused();
    t_count();
    t_zero();
    t_keys();
    t_freeze();
    t_reset_mode();
    t_presc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule